// File: doc/BRIEF.md
# Edge-Sampled Frequency Threshold Detector

This block decides whether a digital input toggles faster than a threshold that can be set at run time, using nothing but the system clock. The input is first brought into the clock domain. Each falling edge of the conditioned input starts a one-shot window that lasts a programmable number of clock cycles. The next rising edge then samples whether that window is still open. The sampled result is kept in an output register until the following rising edge, so the output reads high for a fast input and low for a slow one.

To set the threshold frequency F, program `window_len` to about f_clk / (2·F). In that case the input's low half-period is compared against half the threshold period. If the input duty cycle is far from 50 %, a divide-by-two stage can be switched in. The detector then sees one full input period as its low phase, so `window_len` must be doubled to keep the same threshold. A parameter selects whether the window is built as an active-high or an active-low pulse. The output sense is the same either way.

Top module: `freq_thresh_detect`

## Requirements
- R1: While `rst_n` is low, `fast_out` is 0. After reset it stays 0 until a rising edge of the detection signal samples an open window.
- R2: `fast_out` changes only in the clock cycle after a rising edge of the detection signal is detected. At all other times it holds its value.
- R3: With `prescale_en`=0, a falling edge of the synchronized input opens a window that lasts `window_len` cycles. If the input then stays low for D clock cycles, the next rising edge sets `fast_out` to 1 when D ≤ `window_len` and to 0 otherwise.
- R4: With `prescale_en`=1, the detection signal toggles on every rising edge of the synchronized input. `fast_out` is then 1 exactly when the full input period in clock cycles is ≤ `window_len`.
- R5: A falling edge that arrives while the window is still open reloads the window to its full length.
- R6: When `window_len` is 0, a falling edge leaves the window closed, and the next rising edge drives `fast_out` to 0.
- R7: The parameter `WIN_POL` (WIN_HIGH or WIN_LOW) chooses the internal window polarity. For identical inputs, both settings produce an identical `fast_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous input whose frequency is classified |
| window_len | input | CNT_W | Window length in clock cycles |
| prescale_en | input | 1 | 1 selects the divide-by-two stage |
| fast_out | output | 1 | 1 when the input is faster than the threshold |

## Verification
The bound checker runs on every cycle. It confirms that the output moves only on a detected rising edge and then takes the window state of the previous cycle. It also checks that a falling edge reloads the counter from `window_len`, that the counter steps down by one while open, and that a zero length keeps the window shut. Several properties cannot be seen on a single cycle and are shown only by the bench's square-wave scenarios:
- the overall above/below-threshold decision at the exact boundary D = `window_len`,
- the doubled period seen through the prescaler,
- the benefit of retriggering over a non-retriggerable window,
- the equivalence of the two polarity builds.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
  typedef enum logic {WIN_HIGH = 1'b0, WIN_LOW = 1'b1} win_pol_e;

  // Map a logical "window open" bit to its physical level (and back).
  function automatic logic apply_pol(input logic v, input win_pol_e p);
    return v ^ (p == WIN_LOW);
  endfunction
endpackage

// File: rtl/ftd_sync.sv
module ftd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ftd_prescale.sv
module ftd_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic en,
  output logic q
);
  logic prev_q, half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      prev_q <= d;
      if (d && !prev_q) half_q <= ~half_q;
    end
  end

  assign q = en ? half_q : d;
endmodule

// File: rtl/ftd_edge.sv
module ftd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= d;

  assign rise = d & ~prev_q;
  assign fall = ~d & prev_q;
endmodule

// File: rtl/ftd_oneshot.sv
module ftd_oneshot #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] cnt,
  output logic             active
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Retriggerable down-counter: a start reloads, otherwise count to zero.
  function automatic logic [CNT_W-1:0] next_cnt(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] load,
    input logic             trig
  );
    if (trig)          return load;
    else if (cur != 0) return cur - ONE;
    else               return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= next_cnt(cnt, len, start);

  assign active = (cnt != '0);
endmodule

// File: rtl/freq_thresh_detect.sv
module freq_thresh_detect
  import ftd_pkg::*;
#(
  parameter int       CNT_W       = 16,
  parameter int       SYNC_STAGES = 2,
  parameter win_pol_e WIN_POL     = WIN_HIGH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [CNT_W-1:0] window_len,
  input  logic             prescale_en,
  output logic             fast_out
);
  localparam logic SAMP_RST = apply_pol(1'b0, WIN_POL);

  logic             sync_q, det_sig, rise_evt, fall_evt;
  logic             win_active, win_pulse, samp_q;
  logic [CNT_W-1:0] win_cnt;

  ftd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sig_in), .q(sync_q)
  );

  ftd_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .d(sync_q), .en(prescale_en), .q(det_sig)
  );

  ftd_edge u_edge (
    .clk(clk), .rst_n(rst_n), .d(det_sig), .rise(rise_evt), .fall(fall_evt)
  );

  ftd_oneshot #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .start(fall_evt), .len(window_len),
    .cnt(win_cnt), .active(win_active)
  );

  // Physical window pulse in the chosen polarity.
  assign win_pulse = apply_pol(win_active, WIN_POL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        samp_q <= SAMP_RST;
    else if (rise_evt) samp_q <= win_pulse;

  assign fast_out = apply_pol(samp_q, WIN_POL);
endmodule

// File: rtl/ftd_checker.sv
module ftd_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             win_active,
  input logic             fast_out,
  input logic [CNT_W-1:0] win_cnt,
  input logic [CNT_W-1:0] window_len
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(fast_out));

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (fast_out == $past(win_active)));

  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_evt && win_cnt != '0) |=> (win_cnt == $past(win_cnt) - CNT_W'(1)));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && window_len != '0) |=> (win_cnt == $past(window_len)));

  assert_zero_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && window_len == '0) |=> !win_active);
endmodule

bind freq_thresh_detect ftd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
  .win_active(win_active), .fast_out(fast_out), .win_cnt(win_cnt),
  .window_len(window_len)
);

// File: tb/freq_thresh_detect_test.sv
module freq_thresh_detect_test;
  import ftd_pkg::*;

  localparam int CNT_W = 16;
  localparam int NVEC  = 12;
  // {prescale, window_len, low cycles, high cycles, expected fast}
  localparam bit [33:0] VECS [0:NVEC-1] = '{
    {1'b0, 16'd20, 8'd20, 8'd20, 1'b1},
    {1'b0, 16'd20, 8'd21, 8'd21, 1'b0},
    {1'b0, 16'd20, 8'd19, 8'd19, 1'b1},
    {1'b0, 16'd20, 8'd40, 8'd10, 1'b0},
    {1'b0, 16'd20, 8'd10, 8'd40, 1'b1},
    {1'b1, 16'd40, 8'd20, 8'd20, 1'b1},
    {1'b1, 16'd40, 8'd21, 8'd21, 1'b0},
    {1'b1, 16'd40, 8'd10, 8'd30, 1'b1},
    {1'b1, 16'd40, 8'd30, 8'd30, 1'b0},
    {1'b1, 16'd20, 8'd10, 8'd10, 1'b1},
    {1'b0, 16'd0,  8'd8,  8'd8,  1'b0},
    {1'b0, 16'd0,  8'd2,  8'd10, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sig_in = 1'b0;
  logic [CNT_W-1:0] window_len = '0;
  logic             prescale_en = 1'b0;
  logic             fast_out, fast_out_lo;
  int               n_checks = 0;
  int               n_fails  = 0;

  always #4 clk = ~clk;

  freq_thresh_detect #(.CNT_W(CNT_W), .WIN_POL(WIN_HIGH)) uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .window_len(window_len),
    .prescale_en(prescale_en), .fast_out(fast_out)
  );

  freq_thresh_detect #(.CNT_W(CNT_W), .WIN_POL(WIN_LOW)) uut_lowwin (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .window_len(window_len),
    .prescale_en(prescale_en), .fast_out(fast_out_lo)
  );

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic run_wave(input int lo, input int hi, input int periods);
    for (int p = 0; p < periods; p++) begin
      sig_in = 1'b0; cycles(lo);
      sig_in = 1'b1; cycles(hi);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    cycles(3);
    check("R1 in reset", fast_out, 1'b0);
    rst_n = 1'b1;
    cycles(5);
    check("R1 after reset", fast_out, 1'b0);

    // Vector table: threshold decision with and without the prescaler.
    for (int i = 0; i < NVEC; i++) begin
      logic pre, exp;
      int   len, lo, hi;
      {pre, len, lo, hi, exp} = {VECS[i][33], int'(VECS[i][32:17]),
                                 int'(VECS[i][16:9]), int'(VECS[i][8:1]), VECS[i][0]};
      prescale_en = pre;
      window_len  = CNT_W'(len);
      run_wave(lo, hi, 4);
      // Expected from R3/R4/R6: low time (or full period if prescaled) <= len.
      exp = (len != 0) && ((pre ? lo + hi : lo) <= len);
      check(pre ? "R4 prescaled threshold" :
            (len == 0 ? "R6 zero window" : "R3 threshold"), fast_out, exp);
      check("R7 polarity match", fast_out_lo, fast_out);
    end

    // R5: retrigger during an open window.
    prescale_en = 1'b0;
    window_len  = 16'd20;
    run_wave(30, 10, 2);
    check("R5 preset slow", fast_out, 1'b0);
    sig_in = 1'b0; cycles(15);
    sig_in = 1'b1; cycles(3);
    sig_in = 1'b0; cycles(15);
    sig_in = 1'b1; cycles(10);
    check("R5 retrigger", fast_out, 1'b1);

    // R1: reset in the middle of a fast run.
    rst_n = 1'b0; cycles(1);
    check("R1 mid-run reset", fast_out, 1'b0);
    rst_n = 1'b1; cycles(6);
    check("R1 held after reset", fast_out, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule